// File: doc/BRIEF.md
# Serial Port Interrupt Event Generator

This block is a compact serial transmit and receive engine whose main job is to raise four interrupt request pulses at exactly defined moments. Software writes bytes into a transmit holding stage. The stage is a single register when the FIFO is switched off and a small FIFO when it is switched on. A shift engine sends each byte either as an asynchronous frame or as an 8-bit synchronous transfer with a shift clock. In synchronous mode the engine also captures 8 bits from the serial input into a receive buffer. The bit rate comes from an external baud tick, and autobaud start and end strobes come from an external detector.

The transmit-buffer request normally marks every handoff from the holding stage into the shifter. When the FIFO is enabled and per-transfer signalling is off, it instead marks the moment the FIFO fill level falls to a programmable threshold. The transmit request fires at a different point of the frame in each mode. The receive request accompanies every synchronous frame. A single autobaud request output merges both detector strobes.

Top module: `serial_irq_gen`

## Requirements
- R1: During and directly after reset, `txd` and `sclk` are 1, all four request outputs are 0 and `rx_data` is 0.
- R2: With `sync_mode`=0, a frame is a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. Each bit lasts until the next baud tick. Between frames `txd` is 1.
- R3: With `sync_mode`=1, a frame carries 8 data bits least significant first. `sclk` drops to 0 as the frame is loaded, and each bit spans two baud ticks: `sclk` rises at the first tick and falls, with `txd` moving to the next bit, at the second. After the eighth bit `sclk` stays 1.
- R4: When the FIFO is off, or `per_xfer_req`=1, `irq_txbuf` pulses for one cycle in the very cycle a byte enters the shifter, which is the first cycle of its frame. A write that finds the shifter idle and the holding stage empty starts its frame in the next cycle.
- R5: The holding stage keeps 1 byte with `fifo_en`=0 and DEPTH bytes with `fifo_en`=1, not counting a byte that goes straight into an idle shifter. A write that finds it full is ignored.
- R6: With `fifo_en`=1 and `per_xfer_req`=0, `irq_txbuf` pulses once, in the cycle the fill level falls from above `fifo_thresh` to at or below it. It does not pulse again until the level has risen above the threshold once more.
- R7: In asynchronous mode, `irq_txdone` pulses for one cycle in the first cycle of the stop bit.
- R8: In synchronous mode, `irq_txdone` pulses for one cycle after the eighth bit has completed, in the cycle `sclk` returns high for good.
- R9: In synchronous mode, `rxd` is sampled at each rising `sclk`, least significant bit first. The 8 sampled bits appear on `rx_data` in the same cycle as a one-cycle `irq_rxdone` pulse, which coincides with `irq_txdone`.
- R10: In asynchronous mode, `rx_data` keeps its value and `irq_rxdone` stays 0.
- R11: `irq_autobaud` is 1 in the cycle after either `ab_start` or `ab_end` was 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 selects synchronous mode, 0 selects asynchronous |
| fifo_en | input | 1 | Enables the DEPTH-entry transmit FIFO |
| per_xfer_req | input | 1 | With the FIFO on, 1 keeps one buffer request per transfer |
| fifo_thresh | input | LVL_W | Fill-level threshold for the buffer request |
| tx_wr | input | 1 | Write strobe for the transmit holding stage |
| tx_wdata | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| rxd | input | 1 | Serial data in |
| ab_start | input | 1 | Autobaud start event strobe |
| ab_end | input | 1 | Autobaud end event strobe |
| txd | output | 1 | Serial data out |
| sclk | output | 1 | Synchronous shift clock |
| rx_data | output | 8 | Receive buffer |
| irq_txbuf | output | 1 | Transmit-buffer request pulse |
| irq_txdone | output | 1 | Transmit request pulse |
| irq_rxdone | output | 1 | Receive request pulse |
| irq_autobaud | output | 1 | Merged autobaud request pulse |

## Verification
The properties assume that `sync_mode`, `fifo_en`, `per_xfer_req` and `fifo_thresh` change only while the shifter is idle and the holding stage is empty. They also assume that each autobaud strobe is a single-cycle event. The stimulus reconfigures the block only after every queued byte has been seen leaving on `txd`, and it drives each autobaud strobe for exactly one cycle. The bench decodes every frame from `txd` and `sclk` alone and counts baud ticks to know which bit each request lands on.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 4;
  // async frame: index 0 start, 1..DW data, DW+1 stop
  localparam logic [IDX_W-1:0] ASYNC_STOP  = IDX_W'(DW + 1);
  localparam logic [IDX_W-1:0] ASYNC_LASTD = IDX_W'(DW);
  localparam logic [IDX_W-1:0] SYNC_LAST   = IDX_W'(DW - 1);

  typedef enum logic {MODE_ASYNC = 1'b0, MODE_SYNC = 1'b1} mode_e;

  // line level for asynchronous bit position i
  function automatic logic async_line(input logic [DW-1:0] d, input logic [IDX_W-1:0] i);
    if (i == '0) return 1'b0;
    else if (i <= ASYNC_LASTD) return d[3'(i - 1'b1)];
    else return 1'b1;
  endfunction

  // fill level falls from above the threshold to at or below it
  function automatic logic crossed_down(input int unsigned old_lvl,
                                        input int unsigned new_lvl,
                                        input int unsigned thr);
    return (old_lvl > thr) && (new_lvl <= thr);
  endfunction
endpackage

// File: rtl/serial_irq_txq.sv
module serial_irq_txq
  import serial_irq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic             sh_busy,
  input  logic [LVL_W-1:0] thresh,
  output logic             ld,
  output logic [DW-1:0]    ld_data,
  output logic [LVL_W-1:0] level,
  output logic             thr_hit
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [LVL_W-1:0] cap, level_nxt;
  logic             empty, bypass, push, pop;

  always_comb begin
    cap       = fifo_en ? LVL_W'(DEPTH) : LVL_W'(1);
    empty     = (level == '0);
    bypass    = wr && empty && !sh_busy;
    ld        = !sh_busy && (!empty || wr);
    ld_data   = empty ? wdata : mem[rd_ptr];
    push      = wr && !bypass && (level < cap);
    pop       = ld && !empty;
    level_nxt = level + LVL_W'(push) - LVL_W'(pop);
    thr_hit   = crossed_down(int'(level), int'(level_nxt), int'(thresh));
  end

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      level <= level_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/serial_irq_shift.sv
module serial_irq_shift
  import serial_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          tick,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  output logic          busy,
  output logic          txd,
  output logic          sclk,
  output logic          ev_tx,
  output logic          ev_smp,
  output logic          ev_sdone
);
  logic [DW-1:0]    sh;
  logic [IDX_W-1:0] idx;
  logic             phase;
  logic             adv, ev_astop, ev_aend;

  always_comb begin
    adv      = busy && tick;
    ev_smp   = adv && (mode == MODE_SYNC) && !phase;
    ev_sdone = adv && (mode == MODE_SYNC) && phase && (idx == SYNC_LAST);
    ev_astop = adv && (mode == MODE_ASYNC) && (idx == ASYNC_LASTD);
    ev_aend  = adv && (mode == MODE_ASYNC) && (idx == ASYNC_STOP);
    ev_tx    = ev_astop || ev_sdone;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      phase <= 1'b0;
      sh    <= '0;
      txd   <= 1'b1;
      sclk  <= 1'b1;
    end else if (ld) begin
      busy  <= 1'b1;
      idx   <= '0;
      phase <= 1'b0;
      sh    <= ld_data;
      if (mode == MODE_SYNC) begin
        txd  <= ld_data[0];
        sclk <= 1'b0;
      end else begin
        txd  <= 1'b0;
      end
    end else if (adv) begin
      if (mode == MODE_ASYNC) begin
        if (ev_aend) begin
          busy <= 1'b0;
          idx  <= '0;
          txd  <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          txd <= async_line(sh, idx + 1'b1);
        end
      end else if (!phase) begin
        phase <= 1'b1;
        sclk  <= 1'b1;
      end else if (ev_sdone) begin
        busy  <= 1'b0;
        idx   <= '0;
        phase <= 1'b0;
        txd   <= 1'b1;
      end else begin
        phase <= 1'b0;
        sclk  <= 1'b0;
        idx   <= idx + 1'b1;
        txd   <= sh[3'(idx + 1'b1)];
      end
    end
  end
endmodule

// File: rtl/serial_irq_rxcap.sv
module serial_irq_rxcap
  import serial_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic          done,
  input  logic          rxd,
  output logic [DW-1:0] rbuf
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      rbuf <= '0;
    end else begin
      if (smp)  sh   <= {rxd, sh[DW-1:1]};
      if (done) rbuf <= sh;
    end
  end
endmodule

// File: rtl/serial_irq_gen.sv
module serial_irq_gen
  import serial_irq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             fifo_en,
  input  logic             per_xfer_req,
  input  logic [LVL_W-1:0] fifo_thresh,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  input  logic             baud_tick,
  input  logic             rxd,
  input  logic             ab_start,
  input  logic             ab_end,
  output logic             txd,
  output logic             sclk,
  output logic [7:0]       rx_data,
  output logic             irq_txbuf,
  output logic             irq_txdone,
  output logic             irq_rxdone,
  output logic             irq_autobaud
);
  // named internal events, visible to the bound checker
  logic             sh_busy;
  logic             sh_ld;
  logic [DW-1:0]    sh_ld_data;
  logic [LVL_W-1:0] fifo_level;
  logic             thr_hit;
  logic             ev_tx, ev_smp, ev_sdone;
  logic             per_xfer, txbuf_ev, ab_ev;

  serial_irq_txq #(.DEPTH(DEPTH)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .wr      (tx_wr),
    .wdata   (tx_wdata),
    .sh_busy (sh_busy),
    .thresh  (fifo_thresh),
    .ld      (sh_ld),
    .ld_data (sh_ld_data),
    .level   (fifo_level),
    .thr_hit (thr_hit)
  );

  serial_irq_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (sync_mode),
    .tick     (baud_tick),
    .ld       (sh_ld),
    .ld_data  (sh_ld_data),
    .busy     (sh_busy),
    .txd      (txd),
    .sclk     (sclk),
    .ev_tx    (ev_tx),
    .ev_smp   (ev_smp),
    .ev_sdone (ev_sdone)
  );

  serial_irq_rxcap u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .smp   (ev_smp),
    .done  (ev_sdone),
    .rxd   (rxd),
    .rbuf  (rx_data)
  );

  always_comb begin
    per_xfer = !fifo_en || per_xfer_req;
    txbuf_ev = per_xfer ? sh_ld : thr_hit;
    ab_ev    = ab_start || ab_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_txbuf    <= 1'b0;
      irq_txdone   <= 1'b0;
      irq_rxdone   <= 1'b0;
      irq_autobaud <= 1'b0;
    end else begin
      irq_txbuf    <= txbuf_ev;
      irq_txdone   <= ev_tx;
      irq_rxdone   <= ev_sdone;
      irq_autobaud <= ab_ev;
    end
  end
endmodule

// File: rtl/serial_irq_gen_chk.sv
module serial_irq_gen_chk #(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_mode,
  input logic             fifo_en,
  input logic             per_xfer_req,
  input logic [LVL_W-1:0] fifo_thresh,
  input logic             ab_start,
  input logic             ab_end,
  input logic             txd,
  input logic             sclk,
  input logic             irq_txbuf,
  input logic             irq_txdone,
  input logic             irq_rxdone,
  input logic             irq_autobaud,
  input logic             sh_busy,
  input logic [LVL_W-1:0] fifo_level
);
  assert_idle_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> (txd && sclk));

  assert_xfer_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_txbuf && (!fifo_en || per_xfer_req)) |-> $rose(sh_busy));

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  assert_thresh_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_txbuf && fifo_en && !per_xfer_req) |->
      (fifo_level <= fifo_thresh) && ($past(fifo_level) > fifo_thresh));

  assert_async_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_txdone && !sync_mode) |-> (txd && sh_busy));

  assert_tx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txdone |=> !irq_txdone);

  assert_sync_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_txdone && sync_mode) |-> (sclk && !sh_busy));

  assert_rx_with_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxdone |-> irq_txdone);

  assert_rx_sync_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxdone |-> sync_mode);

  assert_ab_merge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_start || ab_end) |=> irq_autobaud);

  assert_ab_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ab_start || ab_end) |=> !irq_autobaud);
endmodule

bind serial_irq_gen serial_irq_gen_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_mode    (sync_mode),
  .fifo_en      (fifo_en),
  .per_xfer_req (per_xfer_req),
  .fifo_thresh  (fifo_thresh),
  .ab_start     (ab_start),
  .ab_end       (ab_end),
  .txd          (txd),
  .sclk         (sclk),
  .irq_txbuf    (irq_txbuf),
  .irq_txdone   (irq_txdone),
  .irq_rxdone   (irq_rxdone),
  .irq_autobaud (irq_autobaud),
  .sh_busy      (sh_busy),
  .fifo_level   (fifo_level)
);

// File: tb/serial_irq_gen_test.sv
module serial_irq_gen_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0, fifo_en = 1'b0, per_xfer_req = 1'b0;
  logic [LVL_W-1:0] fifo_thresh = '0;
  logic tx_wr = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic baud_tick = 1'b0;
  logic rxd;
  logic ab_start = 1'b0, ab_end = 1'b0;
  logic txd, sclk, irq_txbuf, irq_txdone, irq_rxdone, irq_autobaud;
  logic [7:0] rx_data;

  assign rxd = txd;  // loopback for synchronous receive

  serial_irq_gen #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .fifo_en(fifo_en),
    .per_xfer_req(per_xfer_req), .fifo_thresh(fifo_thresh),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .baud_tick(baud_tick), .rxd(rxd),
    .ab_start(ab_start), .ab_end(ab_end), .txd(txd), .sclk(sclk),
    .rx_data(rx_data), .irq_txbuf(irq_txbuf), .irq_txdone(irq_txdone),
    .irq_rxdone(irq_rxdone), .irq_autobaud(irq_autobaud)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // baud tick every 4 cycles
  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin tcnt <= 0; baud_tick <= 1'b0; end
    else begin
      tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
      baud_tick <= (tcnt == 3);
    end
  end
  logic tick_seen = 1'b0;
  always @(posedge clk) tick_seen <= baud_tick;

  // expected byte queue
  bit [7:0] q [0:511];
  int qw = 0, qr = 0;

  // monitor state
  bit mon_on = 0, per_xfer_exp = 1;
  bit rec = 0, started, slot_new, prev_sclk = 1;
  int slot = 0, nbits = 0, frames = 0;
  int tb_n = 0, tx_n = 0, rx_n = 0, ab_n = 0, tb_frame = 0;
  bit [7:0] acc = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      started = 0; slot_new = 0;
      if (!sync_mode) begin
        if (!rec && txd == 1'b0) begin
          rec = 1; slot = 0; started = 1; frames++; acc = '0;
        end else if (rec && tick_seen) begin
          slot++; slot_new = 1;
          if (slot >= 1 && slot <= 8) acc[slot-1] = txd;
          if (slot == 9) chk(txd == 1'b1, "R2 stop bit level", int'(txd), 1);
          if (slot == 10) begin
            chk(acc == q[qr], "R2 async frame data", int'(acc), int'(q[qr]));
            qr++; rec = 0;
          end
        end
        if (irq_txdone) begin
          tx_n++;
          chk(rec && slot == 9 && slot_new, "R7 transmit request bit index", slot, 9);
        end
        if (irq_rxdone) begin
          rx_n++;
          chk(0, "R10 receive request in async mode", 1, 0);
        end
      end else begin
        if (!rec && sclk == 1'b0) begin
          rec = 1; nbits = 0; started = 1; frames++; acc = '0;
        end else if (rec && sclk && !prev_sclk && nbits < 8) begin
          acc[nbits] = txd; nbits++;
        end
        if (irq_txdone) begin
          tx_n++;
          chk(rec && nbits == 8 && sclk, "R8 transmit request after eighth bit", nbits, 8);
          chk(acc == q[qr], "R3 sync frame data", int'(acc), int'(q[qr]));
          chk(irq_rxdone, "R9 receive request with transmit request", int'(irq_rxdone), 1);
        end
        if (irq_rxdone) begin
          rx_n++;
          chk(rx_data == q[qr], "R9 receive buffer", int'(rx_data), int'(q[qr]));
        end
        if (irq_txdone) begin qr++; rec = 0; end
      end
      if (irq_txbuf) begin
        tb_n++; tb_frame = frames;
        if (per_xfer_exp) chk(started, "R4 buffer request at frame start", int'(started), 1);
      end
      if (irq_autobaud) ab_n++;
      prev_sclk = sclk;
    end
  end

  task automatic wait_idle();
    while (qr != qw) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic send_one(input logic [7:0] b);
    q[qw] = b; qw++;
    @(negedge clk); tx_wr = 1'b1; tx_wdata = b;
    @(negedge clk); tx_wr = 1'b0;
    wait_idle();
  endtask

  // n writes on consecutive cycles; the first 'keep' are expected to be sent
  task automatic burst(input int n, input int keep, input int seed);
    for (int k = 0; k < n; k++) begin
      if (k < keep) begin q[qw] = 8'(seed + k * 29); qw++; end
      @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'(seed + k * 29);
    end
    @(negedge clk); tx_wr = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int tb0, fr0, rx0, ab0;
    logic [7:0] keep_rx;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1 && sclk == 1'b1, "R1 idle lines in reset", int'({txd, sclk}), 3);
    chk({irq_txbuf, irq_txdone, irq_rxdone, irq_autobaud} == 4'b0,
        "R1 requests low in reset", int'({irq_txbuf, irq_txdone, irq_rxdone, irq_autobaud}), 0);
    chk(rx_data == 8'h00, "R1 receive buffer in reset", int'(rx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && sclk && !irq_txbuf && !irq_txdone, "R1 state after reset", int'({txd, sclk}), 3);
    mon_on = 1;

    // R2/R4/R7 async sweep, FIFO off
    tb0 = tb_n;
    for (int k = 0; k < 16; k++) send_one(8'(k * 37 + 11));
    chk(tb_n - tb0 == 16, "R4 buffer request count", tb_n - tb0, 16);
    chk(tx_n == 16, "R7 transmit request count", tx_n, 16);

    // R5 single holding register: third write dropped
    tb0 = tb_n; fr0 = frames;
    burst(3, 2, 8'h5A);
    chk(frames - fr0 == 2, "R5 frames with FIFO off", frames - fr0, 2);
    chk(tb_n - tb0 == 2, "R4 buffer requests with FIFO off", tb_n - tb0, 2);

    // R5 FIFO with per-transfer requests: 1 direct + DEPTH stored, one dropped
    fifo_en = 1'b1; per_xfer_req = 1'b1;
    tb0 = tb_n; fr0 = frames;
    burst(DEPTH + 2, DEPTH + 1, 8'h13);
    chk(frames - fr0 == DEPTH + 1, "R5 frames with FIFO on", frames - fr0, DEPTH + 1);
    chk(tb_n - tb0 == DEPTH + 1, "R4 per-transfer requests with FIFO", tb_n - tb0, DEPTH + 1);

    // R6 threshold rule, threshold 1
    per_xfer_req = 1'b0; fifo_thresh = LVL_W'(1); per_xfer_exp = 0;
    tb0 = tb_n; fr0 = frames;
    burst(DEPTH + 1, DEPTH + 1, 8'h71);
    chk(tb_n - tb0 == 1, "R6 single threshold request", tb_n - tb0, 1);
    chk(tb_frame - fr0 == DEPTH, "R6 request at frame where level reaches threshold", tb_frame - fr0, DEPTH);
    tb0 = tb_n; fr0 = frames;
    burst(3, 3, 8'hC4);
    chk(tb_n - tb0 == 1, "R6 request re-armed after refill", tb_n - tb0, 1);
    chk(tb_frame - fr0 == 2, "R6 position after refill", tb_frame - fr0, 2);
    tb0 = tb_n;
    burst(2, 2, 8'h2E);
    chk(tb_n - tb0 == 0, "R6 no request without rising above threshold", tb_n - tb0, 0);

    // R3/R8/R9 synchronous sweep over all bytes, FIFO off
    fifo_en = 1'b0; per_xfer_exp = 1; sync_mode = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 256; b++) send_one(8'(b));
    chk(rx_n == 256, "R9 receive request count", rx_n, 256);
    chk(rx_data == 8'hFF, "R9 last receive buffer", int'(rx_data), 255);

    // R10 async frames leave receive side alone
    sync_mode = 1'b0; keep_rx = rx_data; rx0 = rx_n;
    @(negedge clk);
    send_one(8'h00);
    send_one(8'h96);
    chk(rx_data == keep_rx, "R10 receive buffer kept in async", int'(rx_data), int'(keep_rx));
    chk(rx_n == rx0, "R10 no receive request in async", rx_n - rx0, 0);

    // R11 autobaud merge
    ab0 = ab_n;
    @(negedge clk); ab_start = 1'b1;
    @(negedge clk); ab_start = 1'b0;
    chk(irq_autobaud == 1'b1, "R11 start strobe", int'(irq_autobaud), 1);
    @(negedge clk);
    chk(irq_autobaud == 1'b0, "R11 pulse width", int'(irq_autobaud), 0);
    ab_end = 1'b1;
    @(negedge clk); ab_end = 1'b0;
    chk(irq_autobaud == 1'b1, "R11 end strobe", int'(irq_autobaud), 1);
    @(negedge clk); ab_start = 1'b1; ab_end = 1'b1;
    @(negedge clk); ab_start = 1'b0; ab_end = 1'b0;
    chk(irq_autobaud == 1'b1, "R11 both strobes", int'(irq_autobaud), 1);
    repeat (2) @(negedge clk);
    chk(ab_n - ab0 == 3, "R11 merged pulse count", ab_n - ab0, 3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule